// File: doc/BRIEF.md
# Real-Time Clock with Selectable Reference Pulse

This block keeps time of day at a resolution of one hundredth of a second. It runs from a 76.8 kHz main clock. A prescaler divides that clock down to a 100 Hz advance strobe. The strobe steps a hundredths counter (0 to 99), and the wrap of that counter steps a seconds counter (0 to 59). Both counters run all the time, whatever the reference mode and whatever the receiver state. The host can load either counter and read it back through a simple address and data port. A load restarts the prescaler, so the next advance comes one full hundredth after the write.

The reference output `ref_out` has four rates, picked by `rate_sel`:

- An irregular fast pulse train that averages 32768 Hz. It comes from a phase accumulator that places 32 pulses in every 75 main clock cycles.
- A 50 Hz square wave.
- A 2 Hz pulse.
- A once-per-minute pulse. This pulse is withheld while the receiver enable is high.

In every mode except the square wave, each pulse lasts exactly one main clock cycle.

Top module: `rtc_ref_top`

## Requirements
- R1: After a synchronous reset both counters read 0 and `ref_out` is low.
- R2: The hundredths counter advances by one every 768 main clock cycles, counted from reset or from the most recent register write.
- R3: When the hundredths counter advances from 99 or above, it becomes 0 and the seconds counter advances. A seconds value of 59 or above becomes 0 on its advance.
- R4: A write with `wr_en` high loads the addressed counter at that clock edge. Address 0x01 takes `wr_data[5:0]` into seconds and address 0x02 takes `wr_data[6:0]` into hundredths. The other data bits are dropped. Writes to any other address change nothing.
- R5: `rd_data` follows `addr` combinationally. Address 0x01 returns seconds in bits 5:0, address 0x02 returns hundredths in bits 6:0, unused bits read 0, and every other address reads 0.
- R6: With `rate_sel` = 0, `ref_out` carries exactly 32 single-cycle pulses in any 75 consecutive cycles, and never two high cycles in a row.
- R7: With `rate_sel` = 1, `ref_out` is a square wave that toggles at the same edge as each hundredths advance and holds its level otherwise.
- R8: With `rate_sel` = 2, `ref_out` is high for one cycle starting at the edge where the hundredths counter becomes 0 or 50.
- R9: With `rate_sel` = 3, `ref_out` is high for one cycle starting at the edge where the time wraps from 59.99 to 0.00, but only if `rx_en` was low at that edge.
- R10: Timekeeping advances identically whatever the values of `rate_sel` and `rx_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 76.8 kHz main clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Reference rate: 0 fast train, 1 square, 2 half-second, 3 minute |
| rx_en | input | 1 | Receiver enable; blocks the minute pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register index for write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| ref_out | output | 1 | Reference pulse or square wave |

## Verification
A prescaler that is off by one count shifts every hundredths advance by a cycle. That shift shows up on `rd_data` and on the half-second and minute pulses at the first advance after a write, within 768 cycles. A bad wrap in the hundredths or seconds counter shows as a wrong read-back, and as a missing or extra pulse at the 0.00 or 0.50 boundary. A phase accumulator with the wrong step or modulus changes the pulse count inside a single 75-cycle window, or produces two adjacent high cycles.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    // Main clock cycles per hundredth of a second at 76.8 kHz
    localparam int PRESCALE   = 768;
    localparam int PRE_W      = $clog2(PRESCALE);

    localparam int HUND_W     = 7;
    localparam int SEC_W      = 6;
    localparam logic [HUND_W-1:0] HUND_TOP  = 7'd99;
    localparam logic [HUND_W-1:0] HUND_HALF = 7'd49;
    localparam logic [SEC_W-1:0]  SEC_TOP   = 6'd59;

    // Fast train: FAST_STEP pulses spread over FAST_MOD cycles
    localparam int FAST_STEP  = 32;
    localparam int FAST_MOD   = 75;
    localparam int ACC_W      = $clog2(FAST_MOD);

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 8;
    localparam logic [ADDR_W-1:0] SEC_IDX  = 8'h01;
    localparam logic [ADDR_W-1:0] HUND_IDX = 8'h02;

    typedef enum logic [1:0] {
        REF_FAST     = 2'd0,
        REF_SQUARE   = 2'd1,
        REF_HALF_SEC = 2'd2,
        REF_MINUTE   = 2'd3
    } ref_mode_e;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [HUND_W-1:0] hund;
    } tod_t;

    function automatic logic [HUND_W-1:0] hund_next(input logic [HUND_W-1:0] v);
        return (v >= HUND_TOP) ? '0 : v + 1'b1;
    endfunction

    function automatic logic [SEC_W-1:0] sec_next(input logic [SEC_W-1:0] v);
        return (v >= SEC_TOP) ? '0 : v + 1'b1;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    logic [PRE_W-1:0] cnt;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(PRESCALE - 1);

    assign tick = (cnt == LAST) && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rtc_time_regs.sv
module rtc_time_regs
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load_sec,
    input  logic              load_hund,
    input  logic [DATA_W-1:0] wdata,
    output tod_t              tod
);
    logic [DATA_W-1:0] unused_wdata;
    assign unused_wdata = wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            tod <= '0;
        end else begin
            if (load_hund)  tod.hund <= wdata[HUND_W-1:0];
            else if (tick)  tod.hund <= hund_next(tod.hund);

            if (load_sec)   tod.sec <= wdata[SEC_W-1:0];
            else if (tick && tod.hund >= HUND_TOP)
                            tod.sec <= sec_next(tod.sec);
        end
    end
endmodule

// File: rtl/rtc_ref_gen.sv
module rtc_ref_gen
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ref_mode_e mode,
    input  logic      rx_en,
    input  logic      tick,
    input  tod_t      tod,
    output logic      fast_pulse,
    output logic      ref_out
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W:0]   acc_sum;
    logic             square_q;
    logic             pulse_q;
    logic             half_hit;
    logic             minute_hit;
    logic             pulse_d;

    assign acc_sum    = {1'b0, acc} + (ACC_W+1)'(FAST_STEP);
    assign fast_pulse = acc_sum >= (ACC_W+1)'(FAST_MOD);

    assign half_hit   = tick && (tod.hund == HUND_HALF || tod.hund >= HUND_TOP);
    assign minute_hit = tick && tod.hund >= HUND_TOP && tod.sec >= SEC_TOP && !rx_en;

    always_comb begin
        case (mode)
            REF_FAST:     pulse_d = fast_pulse;
            REF_HALF_SEC: pulse_d = half_hit;
            REF_MINUTE:   pulse_d = minute_hit;
            default:      pulse_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            square_q <= 1'b0;
            pulse_q  <= 1'b0;
        end else begin
            acc      <= fast_pulse ? ACC_W'(acc_sum - (ACC_W+1)'(FAST_MOD))
                                   : acc_sum[ACC_W-1:0];
            if (tick) square_q <= !square_q;
            pulse_q  <= pulse_d;
        end
    end

    assign ref_out = (mode == REF_SQUARE) ? square_q : pulse_q;
endmodule

// File: rtl/rtc_ref_top.sv
module rtc_ref_top
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        rate_sel,
    input  logic              rx_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              ref_out
);
    logic      load_sec;
    logic      load_hund;
    logic      tick;
    logic      fast_pulse;
    tod_t      tod;
    ref_mode_e mode;

    assign load_sec  = wr_en && (addr == SEC_IDX);
    assign load_hund = wr_en && (addr == HUND_IDX);
    assign mode      = ref_mode_e'(rate_sel);

    rtc_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (load_sec || load_hund),
        .tick    (tick)
    );

    rtc_time_regs u_time (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .load_sec  (load_sec),
        .load_hund (load_hund),
        .wdata     (wr_data),
        .tod       (tod)
    );

    rtc_ref_gen u_ref (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .rx_en      (rx_en),
        .tick       (tick),
        .tod        (tod),
        .fast_pulse (fast_pulse),
        .ref_out    (ref_out)
    );

    always_comb begin
        rd_data = '0;
        if (addr == SEC_IDX)       rd_data[SEC_W-1:0]  = tod.sec;
        else if (addr == HUND_IDX) rd_data[HUND_W-1:0] = tod.hund;
    end
endmodule

// File: rtl/rtc_ref_chk.sv
module rtc_ref_chk
    import rtc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [1:0]        rate_sel,
    input logic              rx_en,
    input logic              tick,
    input logic              fast_pulse,
    input logic [SEC_W-1:0]  sec,
    input logic [HUND_W-1:0] hund,
    input logic              ref_out
);
    logic [ACC_W-1:0] win_cnt;
    logic [ACC_W-1:0] hit_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt <= '0;
            hit_cnt <= '0;
        end else begin
            if (win_cnt == ACC_W'(FAST_MOD - 1)) begin
                // R6
                fast_count_chk: assert (hit_cnt + ACC_W'(fast_pulse) == ACC_W'(FAST_STEP));
                win_cnt <= '0;
                hit_cnt <= '0;
            end else begin
                win_cnt <= win_cnt + 1'b1;
                hit_cnt <= hit_cnt + ACC_W'(fast_pulse);
            end
        end
    end

    // R2
    hund_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && hund < HUND_TOP) |=> (hund == $past(hund) + 1'b1));

    // R3
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && hund >= HUND_TOP && sec >= SEC_TOP) |=> (hund == '0 && sec == '0));

    // R6
    fast_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (rate_sel == 2'd0 && ref_out) |=> (rate_sel != 2'd0 || !ref_out));

    // R7
    square_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rate_sel == 2'd1 && $past(rate_sel) == 2'd1 && !$past(tick)) |-> $stable(ref_out));

    // R9
    minute_block_chk: assert property (@(posedge clk) disable iff (rst)
        (rate_sel == 2'd3 && $past(rate_sel) == 2'd3 && $past(rx_en)) |-> !ref_out);
endmodule

bind rtc_ref_top rtc_ref_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rate_sel   (rate_sel),
    .rx_en      (rx_en),
    .tick       (tick),
    .fast_pulse (fast_pulse),
    .sec        (tod.sec),
    .hund       (tod.hund),
    .ref_out    (ref_out)
);

// File: tb/rtc_ref_top_bench.sv
module rtc_ref_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] rate_sel = 2'd0;
    logic       rx_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       ref_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rtc_ref_top u_rtc_ref_top (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .rx_en(rx_en),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .ref_out(ref_out)
    );

    // {write addr, write data, read addr, expected read}
    localparam logic [31:0] VEC [8] = '{
        {8'h01, 8'h2A, 8'h01, 8'h2A},
        {8'h01, 8'hC5, 8'h01, 8'h05},
        {8'h02, 8'h63, 8'h02, 8'h63},
        {8'h02, 8'hFF, 8'h02, 8'h7F},
        {8'h03, 8'h11, 8'h01, 8'h05},
        {8'h03, 8'h22, 8'h02, 8'h7F},
        {8'h00, 8'h33, 8'h03, 8'h00},
        {8'h01, 8'h3F, 8'h00, 8'h00}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Leaves the bench at the falling edge after the loading edge
    task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_reg(input logic [7:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic       lvl;
        int         cnt;
        logic       prev;
        bit         adj;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        read_reg(8'h01, v); check(v == 8'h00, "R1 sec", v, 0);
        read_reg(8'h02, v); check(v == 8'h00, "R1 hund", v, 0);
        check(ref_out == 1'b0, "R1 ref", ref_out, 0);

        // R4 R5 vector table
        for (int i = 0; i < 8; i++) begin
            write_reg(VEC[i][31:24], VEC[i][23:16]);
            read_reg(VEC[i][15:8], v);
            check(v == VEC[i][7:0], "R4/R5 vector", v, VEC[i][7:0]);
        end

        // R6 fast train over 75 cycles
        rate_sel = 2'd0;
        cnt = 0; prev = 1'b0; adj = 1'b0;
        for (int i = 0; i < 75; i++) begin
            edges(1);
            if (ref_out) cnt++;
            if (ref_out && prev) adj = 1'b1;
            prev = ref_out;
        end
        check(cnt == 32, "R6 count", cnt, 32);
        check(!adj, "R6 adjacent", adj, 0);

        // R2 advance period after write
        write_reg(8'h02, 8'd5);
        edges(767);
        read_reg(8'h02, v); check(v == 8'd5, "R2 before", v, 5);
        edges(1);
        read_reg(8'h02, v); check(v == 8'd6, "R2 after", v, 6);

        // R3 plain carry
        write_reg(8'h01, 8'd10);
        write_reg(8'h02, 8'd99);
        edges(768);
        read_reg(8'h01, v); check(v == 8'd11, "R3 carry sec", v, 11);
        read_reg(8'h02, v); check(v == 8'd0, "R3 carry hund", v, 0);

        // R3 out-of-range seconds wraps to 0
        write_reg(8'h01, 8'd63);
        write_reg(8'h02, 8'd99);
        edges(768);
        read_reg(8'h01, v); check(v == 8'd0, "R3 range wrap", v, 0);

        // R9 minute pulse with receiver off
        rate_sel = 2'd3; rx_en = 1'b0;
        write_reg(8'h01, 8'd59);
        write_reg(8'h02, 8'd99);
        edges(767);
        check(ref_out == 1'b0, "R9 early", ref_out, 0);
        edges(1);
        check(ref_out == 1'b1, "R9 pulse", ref_out, 1);
        edges(1);
        check(ref_out == 1'b0, "R9 width", ref_out, 0);

        // R9 R10 withheld with receiver on, time still wraps
        rx_en = 1'b1;
        write_reg(8'h01, 8'd59);
        write_reg(8'h02, 8'd99);
        edges(768);
        check(ref_out == 1'b0, "R9 blocked", ref_out, 0);
        read_reg(8'h01, v); check(v == 8'd0, "R10 sec", v, 0);
        read_reg(8'h02, v); check(v == 8'd0, "R10 hund", v, 0);
        rx_en = 1'b0;

        // R8 half-second pulse
        rate_sel = 2'd2;
        write_reg(8'h02, 8'd49);
        edges(768);
        check(ref_out == 1'b1, "R8 at 50", ref_out, 1);
        edges(1);
        check(ref_out == 1'b0, "R8 width", ref_out, 0);
        write_reg(8'h02, 8'd30);
        edges(768);
        check(ref_out == 1'b0, "R8 at 31", ref_out, 0);

        // R7 square wave toggles on advance only
        rate_sel = 2'd1;
        write_reg(8'h02, 8'd10);
        lvl = ref_out;
        edges(767);
        check(ref_out == lvl, "R7 hold", ref_out, lvl);
        edges(1);
        check(ref_out == !lvl, "R7 toggle", ref_out, !lvl);
        edges(768);
        check(ref_out == lvl, "R7 toggle back", ref_out, lvl);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule